// File: doc/BRIEF.md
# Dual-Path Carrier Loop Filter

This block is the second-order loop filter of a digital carrier-recovery loop. It takes a signed error sample from a phase or frequency discriminator and produces a signed frequency-correction word for a numerically controlled oscillator. The correction is the sum of two terms. The proportional term is the error scaled by a shift coefficient. The integral term comes from an accumulator that builds up the error, scaled by a second shift coefficient.

Before the integral term is added, its two least significant bits are dropped, which divides it by four. This lines up its LSB with the LSB of the proportional term. Each path has its own 5-bit shift coefficient and its own enable, and both are loaded through a small address/data write port. An input strobe marks each error sample. The correction word is registered and flagged one clock after each sample.

Top module: `carrier_loop_filter`

## Requirements
- R1: A synchronous reset (`rst_n` low at a clock edge) clears `y_out` to 0, `y_vld` to 0, the accumulator to 0, both path enables to off and both coefficients to 0. After reset, a sample therefore produces `y_out` = 0.
- R2: A write with `cfg_we` high stores `cfg_wdata` into one path slot, chosen by `cfg_addr`: 0 selects the proportional path and 1 selects the integral path. Bits 4..0 of the slot hold the shift coefficient and bit 5 holds the path enable (1 = on). A write takes effect for samples from the next clock on.
- R3: With the proportional path on, its term is the 8-bit two's complement error, sign-extended and shifted arithmetically right by the coefficient (0 to 31). This rounds toward minus infinity, so a large shift yields 0 for non-negative errors and -1 for negative ones.
- R4: With the integral path on, each valid sample adds the error, shifted arithmetically right by the integral coefficient, to a 24-bit signed accumulator.
- R5: The accumulator saturates at +8388607 and -8388608 and never wraps. A sample of the opposite sign then moves it back from the limit by exactly the increment.
- R6: `y_out` equals the proportional term plus the updated accumulator shifted arithmetically right by 2 (its two LSBs dropped).
- R7: A disabled path contributes zero. While the integral path is off, the accumulator is held at zero, so re-enabling it restarts integration from zero.
- R8: `y_out` changes only at the clock edge that samples `err_vld` high. It holds its value while `err_vld` is low, and the accumulator does not advance.
- R9: `y_vld` is high for exactly one cycle after each clock edge that samples `err_vld` high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | Slot select: 0 proportional, 1 integral |
| cfg_wdata | input | COEF_W+1 (6) | Bits 4..0 shift coefficient, bit 5 enable |
| err_vld | input | 1 | Error sample strobe |
| err_in | input | ERR_W (8) | Signed error sample |
| y_vld | output | 1 | Correction word updated |
| y_out | output | OUT_W (23) | Signed frequency-correction word |

## Verification
The hardest conditions to reach from the ports are the two saturation limits of the accumulator. With the largest error and a zero shift, each limit takes over 65,000 consecutive samples to reach. The stimulus holds the strobe high for a long unbroken run at +127 with the proportional path off, so the output shows the accumulator alone. It then applies one sample of the opposite sign, which shows that the value left the limit without wrapping. It then clears the integrator by disabling its path, re-enables it, and repeats the run at -128 for the negative limit. Floor rounding of negative values in both shifts is checked with small negative errors, where truncation toward zero would give a different result.

// File: rtl/clf_pkg.sv
package clf_pkg;

   // Configuration slot selected by the write address
   typedef enum logic [0:0] {
      SLOT_PROP  = 1'b0,
      SLOT_INTEG = 1'b1
   } clf_slot_e;

   localparam int unsigned CLF_NUM_SLOTS = 2;

endpackage

// File: rtl/clf_cfg_regs.sv
module clf_cfg_regs
   import clf_pkg::*;
#(
   parameter int unsigned COEF_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic              addr,
   input  logic [COEF_W:0]   wdata,
   output logic [COEF_W-1:0] p_shift,
   output logic              p_en,
   output logic [COEF_W-1:0] i_shift,
   output logic              i_en
);

   localparam int unsigned EN_BIT = COEF_W;

   logic [COEF_W:0] slot_q [CLF_NUM_SLOTS];

   always_ff @(posedge clk) begin
      for (int s = 0; s < int'(CLF_NUM_SLOTS); s++) begin
         if (!rst_n) begin
            slot_q[s] <= '0;
         end else if (we && (addr == 1'(s))) begin
            slot_q[s] <= wdata;
         end
      end
   end

   assign p_shift = slot_q[int'(SLOT_PROP)][COEF_W-1:0];
   assign p_en    = slot_q[int'(SLOT_PROP)][EN_BIT];
   assign i_shift = slot_q[int'(SLOT_INTEG)][COEF_W-1:0];
   assign i_en    = slot_q[int'(SLOT_INTEG)][EN_BIT];

endmodule

// File: rtl/clf_ashift.sv
module clf_ashift #(
   parameter int unsigned IN_W   = 8,
   parameter int unsigned OUT_W  = 24,
   parameter int unsigned SH_W   = 5,
   parameter bit          STAGED = 1'b1
) (
   input  logic signed [IN_W-1:0]  din,
   input  logic        [SH_W-1:0]  sh,
   output logic signed [OUT_W-1:0] dout
);

   if (OUT_W < IN_W) begin : g_bad_width
      $error("clf_ashift: OUT_W must not be smaller than IN_W");
   end

   logic signed [OUT_W-1:0] ext;
   assign ext = OUT_W'(din);

   if (STAGED) begin : g_log_shifter
      logic signed [OUT_W-1:0] stg [SH_W+1];
      assign stg[0] = ext;
      for (genvar i = 0; i < int'(SH_W); i++) begin : g_stage
         assign stg[i+1] = sh[i] ? (stg[i] >>> (2 ** i)) : stg[i];
      end
      assign dout = stg[SH_W];
   end else begin : g_flat_shifter
      assign dout = ext >>> sh;
   end

endmodule

// File: rtl/clf_integrator.sv
module clf_integrator #(
   parameter int unsigned ACC_W    = 24,
   parameter bit          SATURATE = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    step,
   input  logic signed [ACC_W-1:0] inc,
   output logic signed [ACC_W-1:0] acc_q,
   output logic signed [ACC_W-1:0] acc_upd
);

   localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
   localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

   logic signed [ACC_W:0]   sum_w;
   logic signed [ACC_W-1:0] nxt;

   assign sum_w = (ACC_W+1)'(acc_q) + (ACC_W+1)'(inc);

   if (SATURATE) begin : g_sat
      always_comb begin
         if (sum_w[ACC_W] != sum_w[ACC_W-1]) begin
            nxt = sum_w[ACC_W] ? ACC_MIN : ACC_MAX;
         end else begin
            nxt = sum_w[ACC_W-1:0];
         end
      end
   end else begin : g_wrap
      assign nxt = sum_w[ACC_W-1:0];
   end

   assign acc_upd = clr ? '0 : nxt;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         acc_q <= '0;
      end else if (step) begin
         acc_q <= nxt;
      end
   end

endmodule

// File: rtl/clf_combine.sv
module clf_combine #(
   parameter int unsigned ACC_W    = 24,
   parameter int unsigned ALIGN_SH = 2,
   parameter int unsigned OUT_W    = 23
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    step,
   input  logic signed [OUT_W-1:0] prop_term,
   input  logic signed [ACC_W-1:0] acc_upd,
   output logic                    y_vld,
   output logic signed [OUT_W-1:0] y_out
);

   logic signed [ACC_W-1:0] acc_aligned;
   logic signed [OUT_W-1:0] int_term;
   logic signed [OUT_W-1:0] sum_c;

   // Drop the integrator LSBs so both paths share one LSB weight
   assign acc_aligned = acc_upd >>> ALIGN_SH;
   assign int_term    = OUT_W'(acc_aligned);
   assign sum_c       = prop_term + int_term;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         y_vld <= 1'b0;
         y_out <= '0;
      end else begin
         y_vld <= step;
         if (step) begin
            y_out <= sum_c;
         end
      end
   end

endmodule

// File: rtl/carrier_loop_filter.sv
module carrier_loop_filter #(
   parameter int unsigned ERR_W        = 8,
   parameter int unsigned ACC_W        = 24,
   parameter int unsigned COEF_W       = 5,
   parameter int unsigned ALIGN_SH     = 2,
   parameter bit          SATURATE     = 1'b1,
   parameter bit          STAGED_SHIFT = 1'b1,
   localparam int unsigned OUT_W       = ACC_W - ALIGN_SH + 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_we,
   input  logic                    cfg_addr,
   input  logic [COEF_W:0]         cfg_wdata,
   input  logic                    err_vld,
   input  logic signed [ERR_W-1:0] err_in,
   output logic                    y_vld,
   output logic signed [OUT_W-1:0] y_out
);

   if (ACC_W < ERR_W + ALIGN_SH + 1) begin : g_chk_acc
      $error("carrier_loop_filter: ACC_W too small for ERR_W and ALIGN_SH");
   end
   if (COEF_W < 1 || COEF_W > 8) begin : g_chk_coef
      $error("carrier_loop_filter: COEF_W out of range");
   end
   if (ERR_W < 2) begin : g_chk_err
      $error("carrier_loop_filter: ERR_W too small");
   end

   logic [COEF_W-1:0]       p_shift;
   logic [COEF_W-1:0]       i_shift;
   logic                    p_en;
   logic                    i_en;
   logic signed [OUT_W-1:0] prop_raw;
   logic signed [OUT_W-1:0] prop_term;
   logic signed [ACC_W-1:0] int_inc;
   logic signed [ACC_W-1:0] acc_q;
   logic signed [ACC_W-1:0] acc_upd;

   clf_cfg_regs #(
      .COEF_W (COEF_W)
   ) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (cfg_we),
      .addr    (cfg_addr),
      .wdata   (cfg_wdata),
      .p_shift (p_shift),
      .p_en    (p_en),
      .i_shift (i_shift),
      .i_en    (i_en)
   );

   clf_ashift #(
      .IN_W   (ERR_W),
      .OUT_W  (OUT_W),
      .SH_W   (COEF_W),
      .STAGED (STAGED_SHIFT)
   ) u_prop_shift (
      .din  (err_in),
      .sh   (p_shift),
      .dout (prop_raw)
   );

   assign prop_term = p_en ? prop_raw : '0;

   clf_ashift #(
      .IN_W   (ERR_W),
      .OUT_W  (ACC_W),
      .SH_W   (COEF_W),
      .STAGED (STAGED_SHIFT)
   ) u_int_shift (
      .din  (err_in),
      .sh   (i_shift),
      .dout (int_inc)
   );

   clf_integrator #(
      .ACC_W    (ACC_W),
      .SATURATE (SATURATE)
   ) u_integ (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (!i_en),
      .step    (err_vld),
      .inc     (int_inc),
      .acc_q   (acc_q),
      .acc_upd (acc_upd)
   );

   clf_combine #(
      .ACC_W    (ACC_W),
      .ALIGN_SH (ALIGN_SH),
      .OUT_W    (OUT_W)
   ) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (err_vld),
      .prop_term (prop_term),
      .acc_upd   (acc_upd),
      .y_vld     (y_vld),
      .y_out     (y_out)
   );

endmodule

// File: rtl/clf_checker.sv
module clf_checker #(
   parameter int unsigned ERR_W = 8,
   parameter int unsigned ACC_W = 24,
   parameter int unsigned OUT_W = 23
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    err_vld,
   input logic signed [ERR_W-1:0] err_in,
   input logic                    p_en,
   input logic                    i_en,
   input logic signed [ACC_W-1:0] acc_q,
   input logic                    y_vld,
   input logic signed [OUT_W-1:0] y_out
);

   // R1: reset clears outputs, accumulator and enables
   a_r1_reset_clears: assert property (@(posedge clk)
      !rst_n |=> (y_out == '0 && !y_vld && acc_q == '0 && !p_en && !i_en));

   // R9: every sample is flagged in the following cycle
   a_r9_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
      err_vld |=> y_vld);

   // R9: no flag without a sample
   a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !err_vld |=> !y_vld);

   // R8: output holds between samples
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !err_vld |=> $stable(y_out));

   // R7: accumulator held at zero while the integral path is off
   a_r7_int_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !i_en |=> (acc_q == '0));

   // R7: both paths off gives a zero correction
   a_r7_both_off: assert property (@(posedge clk) disable iff (!rst_n)
      (err_vld && !p_en && !i_en) |=> (y_out == '0));

   // R5: non-negative error never lowers the accumulator (no wrap at top)
   a_r5_no_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
      (err_vld && i_en && !err_in[ERR_W-1]) |=> (acc_q >= $past(acc_q)));

   // R5: negative error never raises the accumulator (no wrap at bottom)
   a_r5_no_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
      (err_vld && i_en && err_in[ERR_W-1]) |=> (acc_q <= $past(acc_q)));

endmodule

bind carrier_loop_filter clf_checker #(
   .ERR_W (ERR_W),
   .ACC_W (ACC_W),
   .OUT_W (OUT_W)
) u_clf_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .err_vld (err_vld),
   .err_in  (err_in),
   .p_en    (p_en),
   .i_en    (i_en),
   .acc_q   (acc_q),
   .y_vld   (y_vld),
   .y_out   (y_out)
);

// File: tb/carrier_loop_filter_tb.sv
module carrier_loop_filter_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 180000;
   localparam int NVEC       = 16;

   // Slot words: bit 5 enable, bits 4..0 shift
   localparam int VP [NVEC] = '{32, 34, 35, 63, 63, 1, 1, 1, 1, 32, 32, 1, 1, 1, 36, 36};
   localparam int VI [NVEC] = '{0, 0, 0, 0, 0, 0, 32, 32, 33, 33, 0, 32, 32, 32, 34, 34};
   localparam int VE [NVEC] = '{100, -100, -7, -128, 127, 50, 40, 40, -3, -5, 9, -1, -2, -2, -128, 127};
   localparam int VY [NVEC] = '{100, -25, -1, -1, 0, 0, 10, 20, 19, 13, 9, -1, -1, -2, -18, 5};

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_we = 1'b0;
   logic              cfg_addr = 1'b0;
   logic [5:0]        cfg_wdata = '0;
   logic              err_vld = 1'b0;
   logic signed [7:0] err_in = '0;
   logic              y_vld;
   logic signed [22:0] y_out;

   int checks = 0;
   int failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   carrier_loop_filter dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .err_vld   (err_vld),
      .err_in    (err_in),
      .y_vld     (y_vld),
      .y_out     (y_out)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [5:0] d);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_addr = a;
      cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // Call at a falling edge; returns at the falling edge after the sample
   task automatic smp(input int e);
      err_in = 8'(e);
      err_vld = 1'b1;
      @(negedge clk);
      err_vld = 1'b0;
   endtask

   function automatic string vtag(input int i);
      if (i < 5)       return "R3";
      else if (i == 5) return "R7";
      else if (i < 10) return "R4";
      else if (i < 12) return "R7";
      else             return "R6";
   endfunction

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 y_out", int'(y_out), 0);
      chk("R1 y_vld", int'(y_vld), 0);
      rst_n = 1'b1;
      @(negedge clk);
      smp(100);
      chk("R1 unconfigured sample", int'(y_out), 0);
      chk("R9 pulse high", int'(y_vld), 1);
      @(negedge clk);
      chk("R9 pulse low", int'(y_vld), 0);

      // Vector walk: R2 slot writes, then one sample each
      for (int i = 0; i < NVEC; i++) begin
         wr(1'b0, 6'(VP[i]));
         wr(1'b1, 6'(VI[i]));
         smp(VE[i]);
         chk({vtag(i), " R2 vector"}, int'(y_out), VY[i]);
      end

      // R8: hold with strobe low
      repeat (3) @(negedge clk);
      chk("R8 hold y_out", int'(y_out), 5);
      chk("R8 no flag", int'(y_vld), 0);

      // R5: positive saturation from a long run
      wr(1'b0, 6'h01);
      wr(1'b1, 6'h20);
      err_in = 8'sd127;
      err_vld = 1'b1;
      repeat (66100) @(negedge clk);
      err_vld = 1'b0;
      chk("R5 positive limit", int'(y_out), 2097151);
      smp(-128);
      chk("R5 leave positive limit", int'(y_out), 2097119);

      // R7: disable clears, re-enable restarts
      wr(1'b1, 6'h00);
      smp(0);
      chk("R7 integral off", int'(y_out), 0);
      wr(1'b1, 6'h20);
      err_in = -8'sd128;
      err_vld = 1'b1;
      repeat (65600) @(negedge clk);
      err_vld = 1'b0;
      chk("R5 negative limit", int'(y_out), -2097152);
      smp(127);
      chk("R5 leave negative limit", int'(y_out), -2097121);

      // R1: reset in the middle of operation
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 mid reset y_out", int'(y_out), 0);
      chk("R1 mid reset y_vld", int'(y_vld), 0);
      rst_n = 1'b1;
      @(negedge clk);
      smp(100);
      chk("R1 enables cleared", int'(y_out), 0);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule